// File: doc/BRIEF.md
# Two-Thread Event Counter Time-Slicer

This block lets two hardware threads share a single bank of event counters. Only one thread is counted at a time. A programmable slice timer measures how long the active thread owns the bank. When the slice ends, a fixed swap sequence parks the active thread's counts in per-thread shadow storage and brings back the other thread's parked counts. Counting then resumes for the other thread. Seen from outside, each thread appears to have its own private counters, each advancing only during that thread's slices.

Software programs the slice length and the run control through a two-register write port. Event pulses arrive on one input bit per counter. When a counter wraps past its all-ones value, an interrupt pulse goes out only on the interrupt line of the thread being counted at that moment. A combinational read port returns any counter of either thread, taken from the live bank or from shadow storage as appropriate. The `cur_thread` and `swapping` outputs report the sequencer's position.

The sequencer states are IDLE (stopped), RUN (counting), HALT (counting frozen), SAVE (live values to the active thread's shadow), LOAD (other thread's shadow to the live bank) and STEER (active-thread and interrupt target flipped). Its transitions are:
- start: IDLE to RUN, on an enable write.
- expire: RUN to HALT, when the slice ends.
- stop: RUN to IDLE, on a disable write or when enable is clear.
- the fixed chain HALT to SAVE to LOAD to STEER to RUN.

Top module: `thread_ctr_mux`

## Requirements
- R1: After reset, `cur_thread` is 0, `swapping` is 0, `irq` is 0, and every counter of both threads reads 0.
- R2: A write to register address 1 with bit 0 set, made while stopped, clears every counter of both threads. Thread 0 becomes active and counting begins at the next clock edge.
- R3: While counting (not stopped, `swapping` low), each set bit `evt[i]` at a clock edge adds one to counter i of the active thread, modulo 2^W.
- R4: With a non-zero slice length L (register address 0, in cycles), each slice has exactly L counting cycles. `swapping` is then high for exactly 4 cycles, after which `cur_thread` is inverted, and the pattern repeats.
- R5: Across any number of swaps, each thread's counters equal the events applied while that thread was active and counting.
- R6: Events applied while `swapping` is high are dropped and change no counter of either thread.
- R7: A slice length of 0 disables swapping: `swapping` stays low and `cur_thread` keeps its value.
- R8: An increment that wraps a counter from all ones to zero raises `irq[t]` for exactly one cycle, visible right after that edge, where t is the thread active when the event was counted. The other `irq` bit stays low.
- R9: A write to register address 1 with bit 0 clear stops counting. Afterwards events change no counter, and all counts stay readable.
- R10: While `swapping` is low, `rd_data` is counter `rd_idx` of thread `rd_thr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = slice length, 1 = run control (bit 0 enable) |
| reg_wdata | input | LEN_W | Write data |
| evt | input | N | One increment request per counter |
| rd_thr | input | 1 | Thread selected for readback |
| rd_idx | input | IDX_W | Counter selected for readback |
| rd_data | output | W | Selected counter value |
| cur_thread | output | 1 | Thread currently being counted |
| swapping | output | 1 | Swap sequence in progress |
| irq | output | 2 | Per-thread overflow interrupt pulse |

## Verification
The hardest situation to reach is an overflow on thread 1. A counter of that thread must climb through its full range while thread 1 is active, and thread 1 only becomes active after a full slice and a swap. The bench builds the block with 8-bit counters and sets a slice long enough for 256 events. It idles through thread 0's slice until `cur_thread` turns to 1, then drives one counter continuously. Dropped events are exercised by driving all event bits only in the cycles where `swapping` is observed high.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RUN   = 3'd1,
        S_HALT  = 3'd2,
        S_SAVE  = 3'd3,
        S_LOAD  = 3'd4,
        S_STEER = 3'd5
    } mux_state_e;

    localparam int SWAP_CYCLES = 4;
endpackage

// File: rtl/tcm_slice_timer.sv
module tcm_slice_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LEN_W-1:0] len,
    output logic             expire
);
    logic [LEN_W-1:0] tick_q;

    assign expire = run && (len != '0) && (tick_q >= len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (!run || expire) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end
endmodule

// File: rtl/tcm_live_bank.sv
module tcm_live_bank #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           count_en,
    input  logic           load,
    input  logic [N-1:0]   evt,
    input  logic [N*W-1:0] load_val,
    output logic [N*W-1:0] live,
    output logic           wrap
);
    logic [N-1:0] wrap_v;

    for (genvar i = 0; i < N; i++) begin : g_ctr
        logic [W-1:0] c_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_q <= '0;
            end else if (clear) begin
                c_q <= '0;
            end else if (load) begin
                c_q <= load_val[i*W +: W];
            end else if (count_en && evt[i]) begin
                c_q <= c_q + 1'b1;
            end
        end

        assign wrap_v[i] = count_en && evt[i] && (c_q == {W{1'b1}});
        assign live[i*W +: W] = c_q;
    end

    assign wrap = |wrap_v;
endmodule

// File: rtl/tcm_shadow_bank.sv
module tcm_shadow_bank #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             save,
    input  logic             save_thr,
    input  logic [N*W-1:0]   save_val,
    output logic [2*N*W-1:0] shd
);
    for (genvar t = 0; t < 2; t++) begin : g_thr
        logic [N*W-1:0] s_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_q <= '0;
            end else if (clear) begin
                s_q <= '0;
            end else if (save && (save_thr == t[0])) begin
                s_q <= save_val;
            end
        end

        assign shd[t*N*W +: N*W] = s_q;
    end
endmodule

// File: rtl/thread_ctr_mux.sv
module thread_ctr_mux
    import tcm_pkg::*;
#(
    parameter int N     = 4,
    parameter int W     = 16,
    parameter int LEN_W = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [LEN_W-1:0] reg_wdata,
    input  logic [N-1:0]     evt,
    input  logic             rd_thr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data,
    output logic             cur_thread,
    output logic             swapping,
    output logic [1:0]       irq
);
    mux_state_e st_q, st_d;

    logic [LEN_W-1:0] slice_q;
    logic             en_q;
    logic             cur_q;
    logic [1:0]       irq_q;

    logic en_wr, dis_wr;
    logic run, clear, save, load, flip, expire, wrap;
    logic [N*W-1:0]   live;
    logic [2*N*W-1:0] shd;
    logic [N*W-1:0]   other_shd;

    assign en_wr  = reg_wr && reg_addr && reg_wdata[0];
    assign dis_wr = reg_wr && reg_addr && !reg_wdata[0];

    // Register port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slice_q <= '0;
            en_q    <= 1'b0;
        end else if (reg_wr) begin
            if (!reg_addr) begin
                slice_q <= reg_wdata;
            end else begin
                en_q <= reg_wdata[0];
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (en_wr) st_d = S_RUN;
            S_RUN: begin
                if (!en_q || dis_wr) st_d = S_IDLE;
                else if (expire)     st_d = S_HALT;
            end
            S_HALT:  st_d = S_SAVE;
            S_SAVE:  st_d = S_LOAD;
            S_LOAD:  st_d = S_STEER;
            S_STEER: st_d = S_RUN;
            default: st_d = S_IDLE;
        endcase
    end

    // Outputs of the sequencer
    always_comb begin
        run      = 1'b0;
        swapping = 1'b0;
        clear    = 1'b0;
        save     = 1'b0;
        load     = 1'b0;
        flip     = 1'b0;
        unique case (st_q)
            S_IDLE:  clear = en_wr;
            S_RUN:   run = 1'b1;
            S_HALT:  swapping = 1'b1;
            S_SAVE:  begin swapping = 1'b1; save = 1'b1; end
            S_LOAD:  begin swapping = 1'b1; load = 1'b1; end
            S_STEER: begin swapping = 1'b1; flip = 1'b1; end
            default: ;
        endcase
    end

    // Active thread and interrupt steering
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= 1'b0;
            irq_q <= '0;
        end else begin
            if (clear)     cur_q <= 1'b0;
            else if (flip) cur_q <= ~cur_q;
            irq_q <= '0;
            if (wrap) irq_q[cur_q] <= 1'b1;
        end
    end

    assign cur_thread = cur_q;
    assign irq        = irq_q;

    tcm_slice_timer #(.LEN_W(LEN_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .len    (slice_q),
        .expire (expire)
    );

    assign other_shd = cur_q ? shd[0 +: N*W] : shd[N*W +: N*W];

    tcm_live_bank #(.N(N), .W(W)) u_live (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .count_en (run),
        .load     (load),
        .evt      (evt),
        .load_val (other_shd),
        .live     (live),
        .wrap     (wrap)
    );

    tcm_shadow_bank #(.N(N), .W(W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .save     (save),
        .save_thr (cur_q),
        .save_val (live),
        .shd      (shd)
    );

    // Readback: live bank for the active thread, shadow otherwise
    always_comb begin
        if (!swapping && (rd_thr == cur_q)) begin
            rd_data = live[rd_idx*W +: W];
        end else begin
            rd_data = shd[({1'b0, rd_thr} * N + int'(rd_idx)) * W +: W];
        end
    end

    // Checks
    p_irq_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));

    p_irq_thr0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq[0] |-> !$past(cur_thread));

    p_irq_thr1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |-> $past(cur_thread));

    p_flip_only_after_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_thread != $past(cur_thread)) |-> ($past(swapping) || $past(st_q == S_IDLE)));

    p_zero_slice_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_RUN && slice_q == '0) |=> !swapping);

    p_frozen_in_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_HALT || st_q == S_SAVE || st_q == S_STEER) |=> $stable(live));

    p_frozen_when_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && !en_wr) |=> $stable(live));
endmodule

// File: tb/sim_thread_ctr_mux.sv
`timescale 1ns/1ps
module sim_thread_ctr_mux;
    localparam int N  = 4;
    localparam int BW = 8;
    localparam int LW = 16;
    localparam int IW = 2;
    localparam int NVEC = 5;
    // {slice length, cycles, seed}
    localparam logic [39:0] VEC [NVEC] = '{
        {16'd3,  16'd60,  8'hA5},
        {16'd7,  16'd120, 8'h3C},
        {16'd1,  16'd40,  8'hFF},
        {16'd0,  16'd50,  8'h5A},
        {16'd20, 16'd200, 8'hC3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic reg_addr = 1'b0;
    logic [LW-1:0] reg_wdata = '0;
    logic [N-1:0] evt = '0;
    logic rd_thr = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic [BW-1:0] rd_data;
    logic cur_thread, swapping;
    logic [1:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt [2][N];
    bit running = 0;
    bit done = 0;

    always #2 clk = ~clk;

    thread_ctr_mux #(.N(N), .W(BW), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .evt(evt), .rd_thr(rd_thr), .rd_idx(rd_idx),
        .rd_data(rd_data), .cur_thread(cur_thread), .swapping(swapping), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [LW-1:0] d);
        evt = '0;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic start(input int len);
        wr(1'b0, LW'(len));
        wr(1'b1, 16'd1);
        running = 1;
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < N; i++) exp_cnt[t][i] = 0;
    endtask

    task automatic stop();
        wr(1'b1, 16'd0);
        running = 0;
    endtask

    // one cycle: observe, drive, model; returns at next negedge
    task automatic step(input logic [N-1:0] e);
        evt = e;
        if (running && !swapping)
            for (int i = 0; i < N; i++)
                if (e[i]) exp_cnt[cur_thread][i] = (exp_cnt[cur_thread][i] + 1) % (1 << BW);
        @(negedge clk);
    endtask

    task automatic read_all(input string req);
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < N; i++) begin
                rd_thr = t[0]; rd_idx = IW'(i);
                #0.5;
                chk(req, int'(rd_data), exp_cnt[t][i]);
            end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < N; i++) exp_cnt[t][i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R10 readback
        chk("R1 cur_thread", int'(cur_thread), 0);
        chk("R1 swapping", int'(swapping), 0);
        chk("R1 irq", int'(irq), 0);
        read_all("R1 R10 reset counts");

        // Table walk: R2 R3 R5 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            int len, cyc, seed;
            len  = int'(VEC[v][39:24]);
            cyc  = int'(VEC[v][23:8]);
            seed = int'(VEC[v][7:0]);
            start(len);
            chk("R2 thread0 after enable", int'(cur_thread), 0);
            for (int c = 0; c < cyc; c++)
                step(N'((seed ^ (c * 37)) & 15));
            while (swapping) step('0);
            stop();
            for (int c = 0; c < 10; c++) step(N'(15));  // R9 ignored after stop
            read_all("R3 R5 R9 R10 per-thread counts");
        end

        // R4 slice timing
        start(5);
        cnt = 0;
        for (int c = 0; c < 50 && !swapping; c++) begin cnt++; step('0); end
        chk("R4 counting cycles slice1", cnt, 5);
        cnt = 0;
        for (int c = 0; c < 50 && swapping; c++) begin cnt++; step('0); end
        chk("R4 swap cycles", cnt, 4);
        chk("R4 thread after swap", int'(cur_thread), 1);
        cnt = 0;
        for (int c = 0; c < 50 && !swapping; c++) begin cnt++; step('0); end
        chk("R4 counting cycles slice2", cnt, 5);
        while (swapping) step('0);
        chk("R4 thread after second swap", int'(cur_thread), 0);
        stop();

        // R6 events during swap dropped
        start(4);
        for (int c = 0; c < 40; c++) step(swapping ? N'(15) : N'(0));
        while (swapping) step('0);
        stop();
        read_all("R6 swap events dropped");

        // R7 zero slice
        start(0);
        cnt = 0;
        for (int c = 0; c < 100; c++) begin
            if (swapping) cnt++;
            step(N'(2));
        end
        chk("R7 no swap", cnt, 0);
        chk("R7 thread held", int'(cur_thread), 0);
        stop();
        read_all("R7 counts thread0 only");

        // R8 overflow on thread 0
        start(0);
        cnt = 0;
        for (int c = 0; c < 255; c++) begin
            step(N'(1));
            if (irq != 2'b00) cnt++;
        end
        chk("R8 no early irq t0", cnt, 0);
        step(N'(1));
        chk("R8 irq to thread0", int'(irq), 1);
        step('0);
        chk("R8 irq one cycle t0", int'(irq), 0);
        stop();

        // R8 overflow on thread 1
        start(400);
        for (int c = 0; c < 500 && cur_thread != 1'b1; c++) step('0);
        chk("R8 reached thread1", int'(cur_thread), 1);
        cnt = 0;
        for (int c = 0; c < 255; c++) begin
            step(N'(2));
            if (irq != 2'b00) cnt++;
        end
        chk("R8 no early irq t1", cnt, 0);
        step(N'(2));
        chk("R8 irq to thread1", int'(irq), 2);
        step('0);
        chk("R8 irq one cycle t1", int'(irq), 0);
        stop();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule